// File: doc/BRIEF.md
# Command-Maintained Associative Address Translator

This block is a small, fully associative translation buffer that software fills and maintains with explicit commands. Nothing in it walks page tables. Each slot holds five things:

- a tag taken from the upper virtual address bits;
- a per-slot ignore mask over that tag;
- an address-space number and a shared flag;
- a pair of physical frame numbers;
- a pair of valid bits, one for each frame.

A virtual page pair is mapped onto two frames. The address bit just above the page offset, widened by the mask, chooses between them.

Every cycle a lookup request is resolved combinationally. The result is a hit, an invalid-page miss or a plain miss, together with the frame number and slot index. The same request also raises two flags: an uncacheable flag, decoded from fixed high address bits, and a fault for misaligned instruction fetches. A separate probe port searches the slots for a tag and an address-space number, and returns the slot index or an all-ones miss code. Slots are written by index. A flush command empties the table. A round-robin pointer names a victim slot, shows the contents of that slot, and can be stepped forward.

Top module: `sw_tlb`

## Requirements
- R1: A slot's tag matches the request tag (virtual address bits 31..13) when the two agree in every bit whose mask bit is 0; mask bits set to 1 are ignored.
- R2: A slot matches only when its shared flag is 1 or its stored address-space number equals the request's.
- R3: Slots with both valid bits clear never match. The frame select bit is virtual address bit 12+k, where k is the count of consecutive ones at the low end of the mask. Select 0 uses frame 0 and valid bit 0 (wr_valid[0]); select 1 uses frame 1 and valid bit 1. When the selected valid bit is clear, lk_invalid is raised and lk_hit stays low, with lk_index still naming the slot. lk_pfn is 0 whenever lk_hit is low.
- R4: When several slots match, the lowest-numbered slot supplies the lookup result and the probe result.
- R5: The probe returns the matching slot index, or all ones on pr_index when no slot matches.
- R6: A write replaces every field of the slot named by wr_idx at the next clock edge. A write with wr_idx at or beyond ENTRIES is dropped and changes no slot.
- R7: Flush clears every field of every slot and returns the pointer to 0 at the next edge. It wins over a write issued in the same cycle.
- R8: rp_index names the victim slot and the rp_* outputs show that slot's fields. Each cycle with rp_advance high steps the pointer by one, wrapping from ENTRIES-1 to 0.
- R9: lk_uncached is 1 exactly when lk_va bits 31 and 29 are both 1, whether or not the lookup hits.
- R10: A fetch request (lk_fetch=1) with either of lk_va[1:0] set raises lk_fault and reports neither a hit nor an invalid-page miss.
- R11: Synchronous reset leaves the table and the pointer in the same state as a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space number |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Translation found with a valid frame |
| lk_invalid | output | 1 | Slot matched but the selected frame is invalid |
| lk_fault | output | 1 | Misaligned fetch |
| lk_uncached | output | 1 | Address lies in the uncacheable region |
| lk_index | output | IDX_W | Matching slot |
| lk_pfn | output | PFN_W | Selected physical frame number |
| pr_vpn | input | VPN_W | Probe tag |
| pr_asid | input | ASID_W | Probe address-space number |
| pr_index | output | PR_W | Matching slot or all-ones miss code |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | PR_W | Slot to write |
| wr_vpn | input | VPN_W | Tag to store |
| wr_mask | input | VPN_W | Ignore mask to store |
| wr_asid | input | ASID_W | Address-space number to store |
| wr_global | input | 1 | Shared flag to store |
| wr_pfn0 | input | PFN_W | Frame for select 0 |
| wr_pfn1 | input | PFN_W | Frame for select 1 |
| wr_valid | input | 2 | Valid bits, bit 0 for frame 0 |
| flush | input | 1 | Clear the whole table |
| rp_advance | input | 1 | Step the victim pointer |
| rp_index | output | IDX_W | Victim pointer |
| rp_vpn | output | VPN_W | Victim slot tag |
| rp_mask | output | VPN_W | Victim slot mask |
| rp_asid | output | ASID_W | Victim slot address-space number |
| rp_global | output | 1 | Victim slot shared flag |
| rp_pfn0 | output | PFN_W | Victim slot frame 0 |
| rp_pfn1 | output | PFN_W | Victim slot frame 1 |
| rp_valid | output | 2 | Victim slot valid bits |

## Verification
The bench builds the block with ENTRIES=6 and keeps the other parameters at their 32-bit defaults. With six slots the three-bit write index can still express slots 6 and 7, so dropped out-of-range writes are reachable. The probe miss code 7 differs from every real index. The victim pointer must wrap from 5 to 0 through its own limit logic rather than through natural counter overflow.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    LK_MISS    = 2'd0,
    LK_HIT     = 2'd1,
    LK_INVALID = 2'd2,
    LK_FAULT   = 2'd3
  } lk_kind_e;

  // Length of the run of ones starting at bit 0, limited to w bits.
  function automatic int unsigned trail_ones(input logic [63:0] m, input int unsigned w);
    int unsigned n;
    logic        run;
    n   = 0;
    run = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w && run) begin
        if (m[i]) n++;
        else      run = 1'b0;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic              ent_live,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [VPN_W-1:0]  ent_mask,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ASID_W-1:0] req_asid,
  output logic              match
);
  logic tag_ok;
  logic space_ok;

  always_comb begin
    tag_ok   = ((req_vpn ^ ent_vpn) & ~ent_mask) == '0;
    space_ok = ent_global || (ent_asid == req_asid);
    match    = ent_live && tag_ok && space_ok;
  end
endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int                ENTRIES    = 8,
  parameter int                VA_W       = 32,
  parameter int                PAGE_SHIFT = 12,
  parameter int                ASID_W     = 8,
  parameter int                PFN_W      = 20,
  parameter logic [VA_W-1:0]   UC_MASK    = 32'hA000_0000,
  localparam int               VPN_W      = VA_W - PAGE_SHIFT - 1,
  localparam int               IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int               PR_W       = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_fetch,
  output logic              lk_hit,
  output logic              lk_invalid,
  output logic              lk_fault,
  output logic              lk_uncached,
  output logic [IDX_W-1:0]  lk_index,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [PR_W-1:0]   pr_index,
  input  logic              wr_en,
  input  logic [PR_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic [1:0]        wr_valid,
  input  logic              flush,
  input  logic              rp_advance,
  output logic [IDX_W-1:0]  rp_index,
  output logic [VPN_W-1:0]  rp_vpn,
  output logic [VPN_W-1:0]  rp_mask,
  output logic [ASID_W-1:0] rp_asid,
  output logic              rp_global,
  output logic [PFN_W-1:0]  rp_pfn0,
  output logic [PFN_W-1:0]  rp_pfn1,
  output logic [1:0]        rp_valid
);

  localparam logic [PR_W-1:0] SLOT_LIMIT = PR_W'(ENTRIES);

  // Slot storage, one array per field.
  logic [VPN_W-1:0]  t_vpn    [ENTRIES];
  logic [VPN_W-1:0]  t_mask   [ENTRIES];
  logic [ASID_W-1:0] t_asid   [ENTRIES];
  logic              t_global [ENTRIES];
  logic [PFN_W-1:0]  t_pfn0   [ENTRIES];
  logic [PFN_W-1:0]  t_pfn1   [ENTRIES];
  logic [1:0]        t_valid  [ENTRIES];

  logic             wr_in_range;
  logic [IDX_W-1:0] wr_slot;

  assign wr_in_range = wr_idx < SLOT_LIMIT;
  assign wr_slot     = wr_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int e = 0; e < ENTRIES; e++) begin
        t_vpn[e]    <= '0;
        t_mask[e]   <= '0;
        t_asid[e]   <= '0;
        t_global[e] <= 1'b0;
        t_pfn0[e]   <= '0;
        t_pfn1[e]   <= '0;
        t_valid[e]  <= 2'b00;
      end
    end else if (wr_en && wr_in_range) begin
      t_vpn[wr_slot]    <= wr_vpn;
      t_mask[wr_slot]   <= wr_mask;
      t_asid[wr_slot]   <= wr_asid;
      t_global[wr_slot] <= wr_global;
      t_pfn0[wr_slot]   <= wr_pfn0;
      t_pfn1[wr_slot]   <= wr_pfn1;
      t_valid[wr_slot]  <= wr_valid;
    end
  end

  // Parallel compare for lookup and probe.
  logic [VPN_W-1:0]   lk_tag;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] pr_match;

  assign lk_tag = lk_va[VA_W-1:PAGE_SHIFT+1];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic live;
    assign live = |t_valid[e];

    tlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
      .ent_live  (live),
      .ent_vpn   (t_vpn[e]),
      .ent_mask  (t_mask[e]),
      .ent_asid  (t_asid[e]),
      .ent_global(t_global[e]),
      .req_vpn   (lk_tag),
      .req_asid  (lk_asid),
      .match     (lk_match[e])
    );

    tlb_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_cmp (
      .ent_live  (live),
      .ent_vpn   (t_vpn[e]),
      .ent_mask  (t_mask[e]),
      .ent_asid  (t_asid[e]),
      .ent_global(t_global[e]),
      .req_vpn   (pr_vpn),
      .req_asid  (pr_asid),
      .match     (pr_match[e])
    );
  end

  logic             lk_any;
  logic [IDX_W-1:0] lk_sel;
  logic             pr_any;
  logic [IDX_W-1:0] pr_sel;

  tlb_first_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .req(lk_match),
    .any(lk_any),
    .idx(lk_sel)
  );

  tlb_first_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pr_pick (
    .req(pr_match),
    .any(pr_any),
    .idx(pr_sel)
  );

  assign pr_index = pr_any ? PR_W'(pr_sel) : '1;

  // Frame selection on the winning slot.
  int unsigned      lk_k;
  logic [VA_W-1:0]  lk_shift;
  logic             sel_odd;
  logic             sel_valid;
  logic [PFN_W-1:0] sel_pfn;
  logic             misaligned;
  lk_kind_e         kind;

  always_comb begin
    lk_k       = trail_ones(64'(t_mask[lk_sel]), VPN_W);
    lk_shift   = lk_va >> (PAGE_SHIFT + lk_k);
    sel_odd    = lk_shift[0];
    sel_valid  = sel_odd ? t_valid[lk_sel][1] : t_valid[lk_sel][0];
    sel_pfn    = sel_odd ? t_pfn1[lk_sel] : t_pfn0[lk_sel];
    misaligned = lk_fetch && (lk_va[1:0] != 2'b00);

    if (misaligned)     kind = LK_FAULT;
    else if (!lk_any)   kind = LK_MISS;
    else if (sel_valid) kind = LK_HIT;
    else                kind = LK_INVALID;
  end

  assign lk_hit      = (kind == LK_HIT);
  assign lk_invalid  = (kind == LK_INVALID);
  assign lk_fault    = (kind == LK_FAULT);
  assign lk_pfn      = (kind == LK_HIT) ? sel_pfn : '0;
  assign lk_index    = lk_sel;
  assign lk_uncached = (lk_va & UC_MASK) == UC_MASK;

  // Victim pointer and its slot contents.
  tlb_repl_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk(clk),
    .rst(rst),
    .clr(flush),
    .adv(rp_advance),
    .ptr(rp_index)
  );

  assign rp_vpn    = t_vpn[rp_index];
  assign rp_mask   = t_mask[rp_index];
  assign rp_asid   = t_asid[rp_index];
  assign rp_global = t_global[rp_index];
  assign rp_pfn0   = t_pfn0[rp_index];
  assign rp_pfn1   = t_pfn1[rp_index];
  assign rp_valid  = t_valid[rp_index];

endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int VPN_W   = 19,
  parameter int IDX_W   = 3,
  parameter int PR_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_fetch,
  input logic             lk_hit,
  input logic             lk_invalid,
  input logic             lk_fault,
  input logic [PR_W-1:0]  pr_index,
  input logic             wr_en,
  input logic [PR_W-1:0]  wr_idx,
  input logic             flush,
  input logic             rp_advance,
  input logic [IDX_W-1:0] rp_index,
  input logic [VPN_W-1:0] rp_vpn,
  input logic [1:0]       rp_valid
);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(ENTRIES - 1);
  localparam logic [PR_W-1:0]  LIMIT = PR_W'(ENTRIES);

  // R10: a misaligned fetch never reports a translation
  a_r10_fault_hides_hit: assert property (@(posedge clk) disable iff (rst)
    (lk_fetch && lk_va[1:0] != 2'b00) |-> (!lk_hit && !lk_invalid));

  // R3: outcomes are mutually exclusive
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $countones({lk_hit, lk_invalid, lk_fault}) <= 1);

  // R7: after a flush the probe misses and the pointer sits at an empty slot 0
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pr_index == '1 && rp_index == '0 && rp_valid == 2'b00));

  // R8: pointer steps by one and wraps at the table size
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (!flush && rp_advance) |=>
      rp_index == (($past(rp_index) == LAST) ? '0 : $past(rp_index) + 1'b1));

  // R6: an out-of-range write leaves the slot at the pointer untouched
  a_r6_oob_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && !rp_advance && wr_idx >= LIMIT) |=>
      ($stable(rp_vpn) && $stable(rp_valid)));
endmodule

bind sw_tlb sw_tlb_chk #(
  .ENTRIES(ENTRIES),
  .VA_W   (VA_W),
  .VPN_W  (VPN_W),
  .IDX_W  (IDX_W),
  .PR_W   (PR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_va     (lk_va),
  .lk_fetch  (lk_fetch),
  .lk_hit    (lk_hit),
  .lk_invalid(lk_invalid),
  .lk_fault  (lk_fault),
  .pr_index  (pr_index),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .flush     (flush),
  .rp_advance(rp_advance),
  .rp_index  (rp_index),
  .rp_vpn    (rp_vpn),
  .rp_valid  (rp_valid)
);

// File: tb/sw_tlb_test.sv
`timescale 1ns/1ps
module sw_tlb_test;
  localparam int ENTRIES = 6;
  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int PFN_W   = 20;
  localparam int VPN_W   = 19;
  localparam int IDX_W   = 3;
  localparam int PR_W    = 3;

  localparam logic [VPN_W-1:0] T0 = 19'h00010;
  localparam logic [VPN_W-1:0] T1 = 19'h00020;
  localparam logic [VPN_W-1:0] T3 = 19'h00100;
  localparam logic [VPN_W-1:0] T4 = 19'h00200;
  localparam logic [VPN_W-1:0] T5 = 19'h00300;
  localparam logic [VPN_W-1:0] T6 = 19'h00400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [VA_W-1:0]   lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              lk_fetch = 1'b0;
  logic              lk_hit, lk_invalid, lk_fault, lk_uncached;
  logic [IDX_W-1:0]  lk_index;
  logic [PFN_W-1:0]  lk_pfn;
  logic [VPN_W-1:0]  pr_vpn = '0;
  logic [ASID_W-1:0] pr_asid = '0;
  logic [PR_W-1:0]   pr_index;
  logic              wr_en = 1'b0;
  logic [PR_W-1:0]   wr_idx = '0;
  logic [VPN_W-1:0]  wr_vpn = '0;
  logic [VPN_W-1:0]  wr_mask = '0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic              wr_global = 1'b0;
  logic [PFN_W-1:0]  wr_pfn0 = '0;
  logic [PFN_W-1:0]  wr_pfn1 = '0;
  logic [1:0]        wr_valid = '0;
  logic              flush = 1'b0;
  logic              rp_advance = 1'b0;
  logic [IDX_W-1:0]  rp_index;
  logic [VPN_W-1:0]  rp_vpn, rp_mask;
  logic [ASID_W-1:0] rp_asid;
  logic              rp_global;
  logic [PFN_W-1:0]  rp_pfn0, rp_pfn1;
  logic [1:0]        rp_valid;

  sw_tlb #(.ENTRIES(ENTRIES)) uut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va_of(input logic [VPN_W-1:0] tag, input logic sel,
                                            input logic [11:0] off);
    return {tag, sel, off};
  endfunction

  task automatic wr(input logic [PR_W-1:0] idx, input logic [VPN_W-1:0] vpn,
                    input logic [VPN_W-1:0] mask, input logic [ASID_W-1:0] asid,
                    input logic g, input logic [PFN_W-1:0] p0, input logic [PFN_W-1:0] p1,
                    input logic [1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
    wr_global = g; wr_pfn0 = p0; wr_pfn1 = p1; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid, input logic f);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_fetch = f;
    #1;
  endtask

  task automatic probe(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid);
    @(negedge clk);
    pr_vpn = vpn; pr_asid = asid;
    #1;
  endtask

  task automatic advance(input int n);
    @(negedge clk);
    rp_advance = 1'b1;
    repeat (n) @(negedge clk);
    rp_advance = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R11 ptr after reset", rp_index, 0);
    chk("R11 slot valid after reset", rp_valid, 0);
    probe(19'h0, 8'h0);
    chk("R11 probe miss after reset", pr_index, 7);
    look(32'h0, 8'h0, 1'b0);
    chk("R11 lookup miss after reset", {lk_hit, lk_invalid}, 0);
  endtask

  task automatic t_basic;
    wr(0, T0, 0, 8'h05, 1'b0, 20'h111, 20'h222, 2'b11);
    look(va_of(T0, 1'b0, 12'h010), 8'h05, 1'b0);
    chk("R1 hit even frame", {lk_hit, lk_index, lk_pfn}, {1'b1, 3'd0, 20'h111});
    look(va_of(T0, 1'b1, 12'h000), 8'h05, 1'b0);
    chk("R3 odd frame select", {lk_hit, lk_pfn}, {1'b1, 20'h222});
    look(va_of(T0, 1'b0, 12'h000), 8'h06, 1'b0);
    chk("R2 asid mismatch misses", {lk_hit, lk_invalid, lk_pfn}, 0);
    look(va_of(T0 ^ 19'h1, 1'b0, 12'h000), 8'h05, 1'b0);
    chk("R1 unmasked bit differs", {lk_hit, lk_invalid}, 0);
  endtask

  task automatic t_global;
    wr(1, T1, 0, 8'h00, 1'b1, 20'h333, 20'h444, 2'b11);
    look(va_of(T1, 1'b0, 12'h000), 8'h77, 1'b0);
    chk("R2 shared slot any asid", {lk_hit, lk_index, lk_pfn}, {1'b1, 3'd1, 20'h333});
  endtask

  task automatic t_mask;
    wr(2, T3, 19'h3, 8'h09, 1'b0, 20'h555, 20'h666, 2'b11);
    look(32'(19'h101) << 13, 8'h09, 1'b0);
    chk("R1 masked bit ignored, R3 select bit 14 low", {lk_hit, lk_index, lk_pfn},
        {1'b1, 3'd2, 20'h555});
    look(32'(19'h102) << 13, 8'h09, 1'b0);
    chk("R3 widened select bit high", {lk_hit, lk_pfn}, {1'b1, 20'h666});
    look(32'(19'h104) << 13, 8'h09, 1'b0);
    chk("R1 bit above mask compared", {lk_hit, lk_invalid}, 0);
  endtask

  task automatic t_invalid;
    wr(3, T4, 0, 8'h01, 1'b0, 20'h777, 20'h888, 2'b01);
    look(va_of(T4, 1'b1, 12'h000), 8'h01, 1'b0);
    chk("R3 invalid page", {lk_hit, lk_invalid, lk_index, lk_pfn}, {1'b0, 1'b1, 3'd3, 20'h0});
    look(va_of(T4, 1'b0, 12'h000), 8'h01, 1'b0);
    chk("R3 valid half hits", {lk_hit, lk_pfn}, {1'b1, 20'h777});
    probe(T4, 8'h01);
    chk("R5 probe half-valid slot", pr_index, 3);
    wr(4, T5, 0, 8'h00, 1'b1, 20'h123, 20'h456, 2'b00);
    probe(T5, 8'h00);
    chk("R3 both valid clear never matches", pr_index, 7);
    look(va_of(T5, 1'b0, 12'h000), 8'h00, 1'b0);
    chk("R3 both valid clear lookup", {lk_hit, lk_invalid}, 0);
  endtask

  task automatic t_prio;
    wr(4, T5, 0, 8'h00, 1'b1, 20'haaa, 20'hbbb, 2'b11);
    wr(5, T5, 0, 8'h00, 1'b1, 20'hccc, 20'hddd, 2'b11);
    look(va_of(T5, 1'b0, 12'h000), 8'h42, 1'b0);
    chk("R4 lowest slot wins lookup", {lk_index, lk_pfn}, {3'd4, 20'haaa});
    probe(T5, 8'h42);
    chk("R4 lowest slot wins probe", pr_index, 4);
  endtask

  task automatic t_oob;
    wr(6, T6, 0, 8'h00, 1'b1, 20'h999, 20'h999, 2'b11);
    wr(7, T6, 0, 8'h00, 1'b1, 20'h999, 20'h999, 2'b11);
    probe(T6, 8'h00);
    chk("R6 out-of-range write dropped", pr_index, 7);
    look(va_of(T0, 1'b0, 12'h000), 8'h05, 1'b0);
    chk("R6 slot 0 intact", {lk_hit, lk_pfn}, {1'b1, 20'h111});
    chk("R6 pointer slot intact", rp_vpn, T0);
  endtask

  task automatic t_replace;
    wr(1, T6, 0, 8'h00, 1'b1, 20'h999, 20'h998, 2'b11);
    look(va_of(T1, 1'b0, 12'h000), 8'h77, 1'b0);
    chk("R6 old tag gone", {lk_hit, lk_invalid}, 0);
    probe(T6, 8'h00);
    chk("R6 new tag present", pr_index, 1);
  endtask

  task automatic t_ptr;
    chk("R8 pointer shows slot 0", {rp_index, rp_vpn, rp_pfn0}, {3'd0, T0, 20'h111});
    advance(4);
    chk("R8 pointer at 4", {rp_index, rp_vpn, rp_pfn0}, {3'd4, T5, 20'haaa});
    advance(1);
    chk("R8 pointer at 5", {rp_index, rp_pfn0}, {3'd5, 20'hccc});
    advance(1);
    chk("R8 pointer wraps", rp_index, 0);
    advance(2);
    chk("R8 pointer at 2", {rp_index, rp_mask, rp_asid}, {3'd2, 19'h3, 8'h09});
  endtask

  task automatic t_uc;
    look(32'hA000_0000, 8'h00, 1'b0);
    chk("R9 uncached on miss", {lk_uncached, lk_hit}, {1'b1, 1'b0});
    look(32'h8000_0000, 8'h00, 1'b0);
    chk("R9 bit31 only", lk_uncached, 0);
    look(32'h2000_0000, 8'h00, 1'b0);
    chk("R9 bit29 only", lk_uncached, 0);
    wr(5, 19'h50000, 0, 8'h00, 1'b1, 20'heee, 20'hfff, 2'b11);
    look(32'hA000_0000, 8'h00, 1'b0);
    chk("R9 uncached on hit", {lk_uncached, lk_hit, lk_pfn}, {1'b1, 1'b1, 20'heee});
  endtask

  task automatic t_fault;
    look(va_of(T0, 1'b0, 12'h002), 8'h05, 1'b1);
    chk("R10 fetch bit1 faults", {lk_fault, lk_hit, lk_pfn}, {1'b1, 1'b0, 20'h0});
    look(va_of(T0, 1'b0, 12'h001), 8'h05, 1'b1);
    chk("R10 fetch bit0 faults", {lk_fault, lk_hit}, {1'b1, 1'b0});
    look(va_of(T0, 1'b0, 12'h004), 8'h05, 1'b1);
    chk("R10 aligned fetch hits", {lk_fault, lk_hit}, {1'b0, 1'b1});
    look(va_of(T0, 1'b0, 12'h002), 8'h05, 1'b0);
    chk("R10 data access unaffected", {lk_fault, lk_hit}, {1'b0, 1'b1});
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1;
    wr_en = 1'b1; wr_idx = 0; wr_vpn = T6; wr_mask = 0; wr_asid = 0;
    wr_global = 1'b1; wr_pfn0 = 20'h999; wr_pfn1 = 20'h999; wr_valid = 2'b11;
    @(negedge clk);
    flush = 1'b0; wr_en = 1'b0;
    #1;
    chk("R7 pointer cleared", rp_index, 0);
    chk("R7 slot fields cleared",
        {rp_vpn, rp_mask, rp_asid, rp_global, rp_pfn0, rp_pfn1, rp_valid}, 0);
    probe(T0, 8'h05);
    chk("R7 old slot gone", pr_index, 7);
    probe(T6, 8'h00);
    chk("R7 flush beats write", pr_index, 7);
    look(va_of(T0, 1'b0, 12'h000), 8'h05, 1'b0);
    chk("R7 lookup misses", {lk_hit, lk_invalid}, 0);
    wr(0, T0, 0, 8'h05, 1'b0, 20'h111, 20'h222, 2'b11);
    look(va_of(T0, 1'b0, 12'h000), 8'h05, 1'b0);
    chk("R6 write after flush", {lk_hit, lk_pfn}, {1'b1, 20'h111});
  endtask

  task automatic t_reset2;
    advance(3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 reset clears pointer", rp_index, 0);
    probe(T0, 8'h05);
    chk("R11 reset clears table", pr_index, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_basic();
    t_global();
    t_mask();
    t_invalid();
    t_prio();
    t_oob();
    t_replace();
    t_ptr();
    t_uc();
    t_fault();
    t_flush();
    t_reset2();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule